// File: doc/BRIEF.md
# Aliased Floating-Point Register File

This block is a storage array of sixty-four 32-bit single-precision registers. Four access views share the array. A plain single view addresses one entry. A double view joins two adjacent entries into one 64-bit value. A vector view reaches every fourth entry, and a matrix view reaches every sixteenth entry. Each view has its own index, write enable and write data. All reads are combinational and all writes happen on the rising clock edge. The block does no arithmetic. It only decides which entry each view reaches and which view wins when several write the same entry.

A datapath reads operands through whichever view an operation needs and writes results the same way. The double view needs an even index. An odd index on a double write raises a flag in the same cycle and writes nothing.

Top module: `fpr_alias_file`

## Requirements
- R1: An active-low asynchronous reset clears all 64 entries to zero. `s_rdata` shows entry `s_idx` combinationally.
- R2: With `s_we` high at a rising edge, `s_wdata` is stored in entry `s_idx` and is readable straight after that edge.
- R3: `d_rdata` has entry `d_idx` in bits 63:32 and entry `(d_idx+1) mod 64` in bits 31:0. This holds for odd indices too.
- R4: With `d_we` high and `d_idx` even, `d_wdata[63:32]` is stored in entry `d_idx` and `d_wdata[31:0]` in entry `d_idx+1`.
- R5: `d_misalign` is high in the same cycle exactly when `d_we` is high and `d_idx` is odd. Such a double write changes no entry.
- R6: The vector view uses only `v_idx[3:0]` and reaches entry `v_idx[3:0]*4`, both for reads and for writes. Bits above bit 3 are ignored.
- R7: The matrix view uses only `m_idx[1:0]` and reaches entry `m_idx[1:0]*16`, both for reads and for writes. Bits above bit 1 are ignored.
- R8: When writes in one cycle hit the same entry, the priority is: double over single, single over vector, vector over matrix. Writes to different entries in the same cycle all take effect.
- R9: All four views read and write the same storage, so a write through one view is seen through every view that reaches that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_idx | input | 6 | Single view entry index |
| s_we | input | 1 | Single view write enable |
| s_wdata | input | 32 | Single view write data |
| s_rdata | output | 32 | Single view read data |
| d_idx | input | 6 | Double view first entry index (even) |
| d_we | input | 1 | Double view write enable |
| d_wdata | input | 64 | Double view write data, high word to `d_idx` |
| d_rdata | output | 64 | Double view read data |
| d_misalign | output | 1 | Odd-index double write attempted |
| v_idx | input | 8 | Vector view index, low 4 bits used |
| v_we | input | 1 | Vector view write enable |
| v_wdata | input | 32 | Vector view write data |
| v_rdata | output | 32 | Vector view read data |
| m_idx | input | 8 | Matrix view index, low 2 bits used |
| m_we | input | 1 | Matrix view write enable |
| m_wdata | input | 32 | Matrix view write data |
| m_rdata | output | 32 | Matrix view read data |

## Verification
The two behaviours that can land in the same cycle are the double write and a narrower-view write to an overlapping entry. The same applies to the vector and matrix views meeting at entries 0, 16, 32 and 48. The bench provokes these overlaps with directed cycles and with random phases whose indices are drawn from a small set, so overlaps are frequent. Every read port is compared each cycle against a behavioural model. The model applies the cycle's writes from lowest to highest priority, so the winner is decided independently of the RTL's structure.

// File: rtl/fpr_alias_file.sv
module fpr_alias_file #(
  parameter int WORD_W     = 32,
  parameter int DEPTH      = 64,
  parameter int VEC_STRIDE = 4,
  parameter int MTX_STRIDE = 16,
  parameter int XIDX_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [5:0]            s_idx,
  input  logic                  s_we,
  input  logic [WORD_W-1:0]     s_wdata,
  output logic [WORD_W-1:0]     s_rdata,
  input  logic [5:0]            d_idx,
  input  logic                  d_we,
  input  logic [2*WORD_W-1:0]   d_wdata,
  output logic [2*WORD_W-1:0]   d_rdata,
  output logic                  d_misalign,
  input  logic [XIDX_W-1:0]     v_idx,
  input  logic                  v_we,
  input  logic [WORD_W-1:0]     v_wdata,
  output logic [WORD_W-1:0]     v_rdata,
  input  logic [XIDX_W-1:0]     m_idx,
  input  logic                  m_we,
  input  logic [WORD_W-1:0]     m_wdata,
  output logic [WORD_W-1:0]     m_rdata
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int VSH    = $clog2(VEC_STRIDE);
  localparam int MSH    = $clog2(MTX_STRIDE);
  localparam int VSEL_W = IDX_W - VSH;
  localparam int MSEL_W = IDX_W - MSH;

  logic [WORD_W-1:0] mem [DEPTH];

  logic [IDX_W-1:0] d_lo, v_ent, m_ent;
  logic             d_go;

  assign d_lo       = d_idx + IDX_W'(1);
  assign v_ent      = {v_idx[VSEL_W-1:0], {VSH{1'b0}}};
  assign m_ent      = {m_idx[MSEL_W-1:0], {MSH{1'b0}}};
  assign d_go       = d_we & ~d_idx[0];
  assign d_misalign = d_we & d_idx[0];

  assign s_rdata = mem[s_idx];
  assign d_rdata = {mem[d_idx], mem[d_lo]};
  assign v_rdata = mem[v_ent];
  assign m_rdata = mem[m_ent];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (d_go && d_idx == IDX_W'(e))
          mem[e] <= d_wdata[2*WORD_W-1:WORD_W];
        else if (d_go && d_lo == IDX_W'(e))
          mem[e] <= d_wdata[WORD_W-1:0];
        else if (s_we && s_idx == IDX_W'(e))
          mem[e] <= s_wdata;
        else if (v_we && v_ent == IDX_W'(e))
          mem[e] <= v_wdata;
        else if (m_we && m_ent == IDX_W'(e))
          mem[e] <= m_wdata;
      end
    end
  end
endmodule

// File: rtl/fpr_alias_file_chk.sv
module fpr_alias_file_chk #(
  parameter int WORD_W     = 32,
  parameter int DEPTH      = 64,
  parameter int VEC_STRIDE = 4,
  parameter int MTX_STRIDE = 16,
  parameter int XIDX_W     = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [5:0]          s_idx,
  input logic                s_we,
  input logic [WORD_W-1:0]   s_wdata,
  input logic [WORD_W-1:0]   s_rdata,
  input logic [5:0]          d_idx,
  input logic                d_we,
  input logic [2*WORD_W-1:0] d_wdata,
  input logic [2*WORD_W-1:0] d_rdata,
  input logic                d_misalign,
  input logic [XIDX_W-1:0]   v_idx,
  input logic                v_we,
  input logic [WORD_W-1:0]   v_wdata,
  input logic [WORD_W-1:0]   v_rdata,
  input logic [XIDX_W-1:0]   m_idx,
  input logic                m_we,
  input logic [WORD_W-1:0]   m_wdata,
  input logic [WORD_W-1:0]   m_rdata
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int VSH   = $clog2(VEC_STRIDE);
  localparam int MSH   = $clog2(MTX_STRIDE);

  logic [IDX_W-1:0] v_at, m_at;
  assign v_at = {v_idx[IDX_W-VSH-1:0], {VSH{1'b0}}};
  assign m_at = {m_idx[IDX_W-MSH-1:0], {MSH{1'b0}}};

  assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_we && !(d_we && !d_idx[0])) |=>
      (s_idx != $past(s_idx)) || (s_rdata == $past(s_wdata)));

  assert_double_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (d_we && !d_idx[0]) |=>
      (d_idx != $past(d_idx)) || (d_rdata == $past(d_wdata)));

  assert_odd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (d_misalign && !s_we && !v_we && !m_we) |=>
      (d_idx != $past(d_idx)) || (d_rdata == $past(d_rdata)));

  assert_vec_alias_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_idx == v_at) |-> (s_rdata == v_rdata));

  assert_mtx_alias_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_idx == m_at) |-> (s_rdata == m_rdata));

  assert_pair_alias_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_idx == d_idx) |-> (s_rdata == d_rdata[2*WORD_W-1:WORD_W]));
endmodule

bind fpr_alias_file fpr_alias_file_chk #(
  .WORD_W(WORD_W), .DEPTH(DEPTH), .VEC_STRIDE(VEC_STRIDE),
  .MTX_STRIDE(MTX_STRIDE), .XIDX_W(XIDX_W)
) u_chk (.*);

// File: tb/fpr_alias_file_tb_top.sv
`timescale 1ns/1ps
module fpr_alias_file_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [5:0]  s_idx = '0, d_idx = '0;
  logic        s_we = 0, d_we = 0, v_we = 0, m_we = 0;
  logic [31:0] s_wdata = '0, v_wdata = '0, m_wdata = '0;
  logic [63:0] d_wdata = '0;
  logic [7:0]  v_idx = '0, m_idx = '0;
  logic [31:0] s_rdata, v_rdata, m_rdata;
  logic [63:0] d_rdata;
  logic        d_misalign;

  fpr_alias_file dut_i (.*);

  logic [31:0] model [64];
  int checks = 0, fails = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R1 single read", 64'(s_rdata), 64'(model[s_idx]));
    chk("R3 double read", d_rdata, {model[d_idx], model[6'(d_idx + 6'd1)]});
    chk("R6 vector read", 64'(v_rdata), 64'(model[{v_idx[3:0], 2'b00}]));
    chk("R7 matrix read", 64'(m_rdata), 64'(model[{m_idx[1:0], 4'b0000}]));
    chk("R5 misalign flag", 64'(d_misalign), 64'(d_we && d_idx[0]));
  endtask

  // lowest priority first, so later writes win (R8)
  task automatic commit();
    if (m_we) model[{m_idx[1:0], 4'b0000}] = m_wdata;
    if (v_we) model[{v_idx[3:0], 2'b00}] = v_wdata;
    if (s_we) model[s_idx] = s_wdata;
    if (d_we && !d_idx[0]) begin
      model[d_idx] = d_wdata[63:32];
      model[6'(d_idx + 6'd1)] = d_wdata[31:0];
    end
  endtask

  task automatic cycle();
    #1 compare();
    @(posedge clk);
    commit();
    @(negedge clk);
  endtask

  task automatic idle();
    s_we = 0; d_we = 0; v_we = 0; m_we = 0;
  endtask

  task automatic scan_all();
    idle();
    for (int k = 0; k < 64; k++) begin
      s_idx = 6'(k); d_idx = 6'(k); v_idx = 8'($urandom); m_idx = 8'($urandom);
      #1 compare();
    end
  endtask

  initial begin
    for (int k = 0; k < 64; k++) model[k] = '0;
    #1;
    for (int k = 0; k < 8; k++) begin
      s_idx = 6'(k * 9); #1 chk("R1 reset value", 64'(s_rdata), 64'd0);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    scan_all();

    // R2 single write, R9 seen through double low half
    idle(); s_we = 1; s_idx = 6'd5; s_wdata = 32'hA5A5_0005; cycle();
    idle(); s_idx = 6'd5; d_idx = 6'd4; cycle();
    chk("R9 single via double low", d_rdata[31:0], 64'h0000_0000_A5A5_0005);

    // R4 double write, top entry pair
    idle(); d_we = 1; d_idx = 6'd62; d_wdata = 64'h1111_2222_3333_4444; cycle();
    idle(); s_idx = 6'd63; cycle();
    chk("R4 low half in i+1", 64'(s_rdata), 64'h3333_4444);
    // R3 odd read wraps to entry 0
    idle(); d_idx = 6'd63; cycle();

    // R5 odd write suppressed
    idle(); d_we = 1; d_idx = 6'd7; d_wdata = 64'hDEAD_BEEF_CAFE_F00D; cycle();
    idle(); d_idx = 6'd6; s_idx = 6'd7; cycle();
    chk("R5 odd write left entry 7", 64'(s_rdata), 64'd0);

    // R6 and R7 upper index bits ignored
    idle(); v_we = 1; v_idx = 8'hF3; v_wdata = 32'h0000_0C0C; cycle();
    idle(); m_we = 1; m_idx = 8'hFE; m_wdata = 32'h0000_2020; cycle();
    idle(); s_idx = 6'd12; cycle();
    chk("R6 vector entry 12", 64'(s_rdata), 64'h0C0C);
    s_idx = 6'd32; cycle();
    chk("R7 matrix entry 32", 64'(s_rdata), 64'h2020);

    // R8 all views at once
    idle();
    d_we = 1; d_idx = 6'd4; d_wdata = 64'h4444_4444_5555_5555;
    s_we = 1; s_idx = 6'd5; s_wdata = 32'h0BAD_0005;
    v_we = 1; v_idx = 8'h01; v_wdata = 32'h0BAD_0004;
    m_we = 1; m_idx = 8'h00; m_wdata = 32'h0000_0E00;
    cycle();
    idle(); s_idx = 6'd5; cycle();
    chk("R8 double beats single", 64'(s_rdata), 64'h5555_5555);
    // single over vector, vector over matrix
    idle(); s_we = 1; s_idx = 6'd8; s_wdata = 32'h5;
    v_we = 1; v_idx = 8'h02; v_wdata = 32'h6; cycle();
    idle(); v_we = 1; v_idx = 8'h10; v_wdata = 32'h7;
    m_we = 1; m_idx = 8'h04; m_wdata = 32'h8; cycle();
    idle(); s_idx = 6'd0; cycle();
    chk("R8 vector beats matrix", 64'(s_rdata), 64'h7);
    // odd double does not block single
    idle(); d_we = 1; d_idx = 6'd3; d_wdata = '1;
    s_we = 1; s_idx = 6'd3; s_wdata = 32'h33; cycle();
    scan_all();

    for (int n = 0; n < 4000; n++) begin
      s_we = 1'($urandom); d_we = 1'($urandom); v_we = 1'($urandom); m_we = 1'($urandom);
      s_wdata = $urandom; v_wdata = $urandom; m_wdata = $urandom;
      d_wdata = {$urandom, $urandom};
      if (n % 3 == 0) begin
        s_idx = 6'($urandom_range(0, 5)); d_idx = 6'($urandom_range(0, 5));
        v_idx = {4'($urandom), 4'($urandom_range(0, 1))};
        m_idx = {6'($urandom), 2'b00};
      end else begin
        s_idx = 6'($urandom); d_idx = 6'($urandom);
        v_idx = 8'($urandom); m_idx = 8'($urandom);
      end
      cycle();
    end
    scan_all();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule